// File: doc/BRIEF.md
# Zero-Operand 8-bit Stack Processor Core

This core runs byte-coded programs out of one shared 256-byte memory. It keeps one working value in a TOP register. Below TOP sits a data stack whose index counts downward. A separate return stack holds subroutine return addresses. No instruction names a register. Every opcode is one byte. An instruction that needs an address or a literal takes it from the byte that follows the opcode. That byte can be used as it stands, or it can be dereferenced through memory once or twice. One instruction performs a read-modify-write increment through a pointer held in memory.

The core drives a single address bus, a write-data bus and a write strobe, and it takes read data back on a separate bus. Memory must answer with a fixed latency of one cycle. An address presented during cycle k is captured at the edge that ends k. The data for it is sampled at the edge that ends cycle k+1. A write completes at the edge that ends the cycle in which the strobe is high. The port has no valid/ready handshake: the memory can never stall the core, and the core never holds the bus. Each instruction runs as a fixed sequence of two to five cycles. The first cycle always reads the opcode at PC.

Both stacks are eight entries deep. The stack depths are parameters.

Top module: `sp_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the core reads address 0x00 with the write strobe low. Reset also clears TOP to 0x00 and empties both stacks.
- R2: Opcodes are 0x00 nop, 0x01 lit, 0x02 pop, 0x03 sta, 0x04 ldrot, 0x05 jmp, 0x06 bnz, 0x07 bz, 0x08 add, 0x09 sub, 0x0A setn, 0x0B pushi, 0x0C n2t, 0x0D swap, 0x0E t2n, 0x0F incp, 0x10 sti, 0x11 call and 0x12 ret. Any other byte executes as a two-cycle nop and changes neither TOP, the stacks nor memory.
- R3: Memory has a one-cycle read latency. The core never drives the write strobe high in two consecutive cycles.
- R4: lit pushes its operand: the index steps down, then the value is written. pop moves the stack entry N into TOP and steps the index up. A push onto a full stack is dropped. A pop from an empty stack loads 0x00 into TOP and leaves the index unchanged.
- R5: add replaces N with (N + TOP) mod 256. sub replaces N with (N - TOP) mod 256. The stack depth does not change.
- R6: swap exchanges N and TOP. t2n copies TOP into N. n2t copies N into TOP. setn overwrites N with its operand.
- R7: sta writes N to memory at the operand address. ldrot loads N into TOP and replaces N with mem[operand].
- R8: pushi pushes mem[mem[operand]]. sti writes N to mem[mem[operand]]. incp adds 1 modulo 256 to mem[mem[operand]].
- R9: jmp loads PC with its operand. bz branches when TOP is 0x00 and bnz branches when TOP is not 0x00. A branch that is not taken continues at PC+2.
- R10: call pushes PC+2 on the return stack and jumps to its operand. ret pops that value into PC. Calls can nest.
- R11: Instructions without an operand take 2 cycles. lit, sta, setn, jmp, bz, bnz and call take 3. ldrot and sti take 4. pushi and incp take 5. The write of sta, sti and incp comes in the last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for the current cycle |
| mem_wdata | output | 8 | Write data, valid when mem_we is high |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |
| mem_we | output | 1 | Write strobe |

## Verification
A wrong stack index or a bad TOP value does not show at once. It stays hidden until a later sta, sti or incp writes a wrong byte, or until a branch on TOP picks the wrong path. The tests therefore end each short program by storing the values they care about, so every fault lands in memory within a few instructions. A state sequence with the wrong length moves the first write strobe by whole cycles. This is caught exactly by counting cycles from reset to the first write. A bad branch or return target shows in the very next cycle, as a wrong address on the fetch.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int WORD_W = 8;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_LIT   = 8'h01;
  localparam logic [7:0] OP_POP   = 8'h02;
  localparam logic [7:0] OP_STA   = 8'h03;
  localparam logic [7:0] OP_LDROT = 8'h04;
  localparam logic [7:0] OP_JMP   = 8'h05;
  localparam logic [7:0] OP_BNZ   = 8'h06;
  localparam logic [7:0] OP_BZ    = 8'h07;
  localparam logic [7:0] OP_ADD   = 8'h08;
  localparam logic [7:0] OP_SUB   = 8'h09;
  localparam logic [7:0] OP_SETN  = 8'h0A;
  localparam logic [7:0] OP_PUSHI = 8'h0B;
  localparam logic [7:0] OP_N2T   = 8'h0C;
  localparam logic [7:0] OP_SWAP  = 8'h0D;
  localparam logic [7:0] OP_T2N   = 8'h0E;
  localparam logic [7:0] OP_INCP  = 8'h0F;
  localparam logic [7:0] OP_STI   = 8'h10;
  localparam logic [7:0] OP_CALL  = 8'h11;
  localparam logic [7:0] OP_RET   = 8'h12;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_OPND,
    S_DEREF1,
    S_DEREF2
  } state_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_INC
  } alu_op_e;
endpackage

// File: rtl/sp_alu.sv
module sp_alu
  import sp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = a + W'(1);
    endcase
  end
endmodule

// File: rtl/sp_stack.sv
// Descending-index LIFO. idx == DEPTH means empty, idx == 0 means full.
// At most one of push, pop and wr is expected per cycle; push wins.
module sp_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       wr,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] idx
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(DEPTH+1);
  localparam logic [IW-1:0] IDX_EMPTY = IW'(DEPTH);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_dn;
  logic [W-1:0]  rd_vec [DEPTH];

  assign idx_dn = idx_q - 1'b1;
  assign empty  = (idx_q == IDX_EMPTY);
  assign full   = (idx_q == '0);
  assign idx    = idx_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (push && !full && idx_dn[AW-1:0] == AW'(i)) begin
        q <= din;
      end else if (!push && wr && !empty && idx_q[AW-1:0] == AW'(i)) begin
        q <= din;
      end
    end
    assign rd_vec[i] = q;
  end

  assign dout = empty ? '0 : rd_vec[idx_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= IDX_EMPTY;
    end else if (push && !full) begin
      idx_q <= idx_dn;
    end else if (!push && pop && !empty) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sp_core.sv
module sp_core #(
  parameter int DS_DEPTH = 8,
  parameter int RS_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic       mem_we
);
  import sp_pkg::*;

  localparam int W     = WORD_W;
  localparam int DS_IW = $clog2(DS_DEPTH+1);
  localparam int RS_IW = $clog2(RS_DEPTH+1);

  state_e state_q, state_d;
  logic [W-1:0] pc_q, pc_d, top_q, top_d, ir_q, ir_d, link_q, link_d;
  logic [W-1:0] pc_p1, pc_p2;

  logic             ds_push, ds_pop, ds_wr, ds_empty, ds_full;
  logic [W-1:0]     ds_din, ds_top;
  logic [DS_IW-1:0] ds_idx;

  logic             rs_push, rs_pop, rs_empty, rs_full;
  logic [W-1:0]     rs_top;
  logic [RS_IW-1:0] rs_idx;

  alu_op_e      alu_op;
  logic [W-1:0] alu_a, alu_b, alu_y;

  logic [W-1:0] addr_c, wdata_c;
  logic         we_c;
  logic         top_zero;

  assign pc_p1    = pc_q + W'(1);
  assign pc_p2    = pc_q + W'(2);
  assign top_zero = (top_q == '0);

  sp_stack #(.W(W), .DEPTH(DS_DEPTH)) u_dstack (
    .clk(clk), .rst(rst), .push(ds_push), .pop(ds_pop), .wr(ds_wr),
    .din(ds_din), .dout(ds_top), .empty(ds_empty), .full(ds_full), .idx(ds_idx)
  );

  sp_stack #(.W(W), .DEPTH(RS_DEPTH)) u_rstack (
    .clk(clk), .rst(rst), .push(rs_push), .pop(rs_pop), .wr(1'b0),
    .din(pc_p2), .dout(rs_top), .empty(rs_empty), .full(rs_full), .idx(rs_idx)
  );

  sp_alu #(.W(W)) u_alu (.op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    top_d   = top_q;
    ir_d    = ir_q;
    link_d  = link_q;
    ds_push = 1'b0;
    ds_pop  = 1'b0;
    ds_wr   = 1'b0;
    ds_din  = mem_rdata;
    rs_push = 1'b0;
    rs_pop  = 1'b0;
    alu_op  = ALU_ADD;
    alu_a   = ds_top;
    alu_b   = top_q;
    addr_c  = pc_q;
    wdata_c = ds_top;
    we_c    = 1'b0;

    unique case (state_q)
      S_FETCH: begin
        addr_c  = pc_q;
        state_d = S_DECODE;
      end

      S_DECODE: begin
        ir_d    = mem_rdata;
        pc_d    = pc_p1;
        state_d = S_FETCH;
        case (mem_rdata)
          OP_POP: begin
            top_d  = ds_top;
            ds_pop = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            alu_op = (mem_rdata == OP_ADD) ? ALU_ADD : ALU_SUB;
            ds_din = alu_y;
            ds_wr  = 1'b1;
          end
          OP_N2T: top_d = ds_top;
          OP_SWAP: begin
            top_d  = ds_top;
            ds_din = top_q;
            ds_wr  = 1'b1;
          end
          OP_T2N: begin
            ds_din = top_q;
            ds_wr  = 1'b1;
          end
          OP_RET: begin
            pc_d   = rs_top;
            rs_pop = 1'b1;
          end
          OP_LIT, OP_STA, OP_LDROT, OP_JMP, OP_BNZ, OP_BZ, OP_SETN,
          OP_PUSHI, OP_INCP, OP_STI, OP_CALL: begin
            pc_d    = pc_q;
            addr_c  = pc_p1;
            state_d = S_OPND;
          end
          default: ;
        endcase
      end

      S_OPND: begin
        pc_d    = pc_p2;
        state_d = S_FETCH;
        case (ir_q)
          OP_LIT:  ds_push = 1'b1;
          OP_SETN: ds_wr   = 1'b1;
          OP_STA: begin
            addr_c = mem_rdata;
            we_c   = 1'b1;
          end
          OP_JMP: pc_d = mem_rdata;
          OP_BZ:  pc_d = top_zero ? mem_rdata : pc_p2;
          OP_BNZ: pc_d = top_zero ? pc_p2 : mem_rdata;
          OP_CALL: begin
            rs_push = 1'b1;
            pc_d    = mem_rdata;
          end
          OP_LDROT, OP_PUSHI, OP_INCP, OP_STI: begin
            pc_d    = pc_q;
            addr_c  = mem_rdata;
            state_d = S_DEREF1;
          end
          default: ;
        endcase
      end

      S_DEREF1: begin
        pc_d    = pc_p2;
        state_d = S_FETCH;
        case (ir_q)
          OP_LDROT: begin
            top_d = ds_top;
            ds_wr = 1'b1;
          end
          OP_STI: begin
            addr_c = mem_rdata;
            we_c   = 1'b1;
          end
          OP_PUSHI, OP_INCP: begin
            pc_d    = pc_q;
            addr_c  = mem_rdata;
            link_d  = mem_rdata;
            state_d = S_DEREF2;
          end
          default: ;
        endcase
      end

      S_DEREF2: begin
        pc_d    = pc_p2;
        state_d = S_FETCH;
        if (ir_q == OP_INCP) begin
          alu_op  = ALU_INC;
          alu_a   = mem_rdata;
          addr_c  = link_q;
          wdata_c = alu_y;
          we_c    = 1'b1;
        end else begin
          ds_push = 1'b1;
        end
      end

      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      top_q   <= '0;
      ir_q    <= '0;
      link_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      top_q   <= top_d;
      ir_q    <= ir_d;
      link_q  <= link_d;
    end
  end

  assign mem_addr  = addr_c;
  assign mem_wdata = wdata_c;
  assign mem_we    = we_c & ~rst;
endmodule

// File: rtl/sp_core_chk.sv
module sp_core_chk
  import sp_pkg::*;
#(
  parameter int DS_DEPTH = 8,
  parameter int RS_DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [7:0]                    mem_addr,
  input logic [7:0]                    mem_rdata,
  input logic                          mem_we,
  input state_e                        state_q,
  input logic [7:0]                    ir_q,
  input logic                          ds_push,
  input logic                          ds_pop,
  input logic                          ds_full,
  input logic                          ds_empty,
  input logic [$clog2(DS_DEPTH+1)-1:0] ds_idx,
  input logic                          rs_full,
  input logic                          rs_empty,
  input logic [$clog2(RS_DEPTH+1)-1:0] rs_idx
);
  localparam int DIW = $clog2(DS_DEPTH+1);
  localparam int RIW = $clog2(RS_DEPTH+1);

  a_r1_reset_fetch_zero: assert property (@(posedge clk)
    rst |=> (mem_addr == 8'h00 && !mem_we));

  a_r3_no_back_to_back_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r4_push_steps_down: assert property (@(posedge clk) disable iff (rst)
    (ds_push && !ds_full) |=> (ds_idx == $past(ds_idx) - 1'b1));

  a_r4_pop_steps_up: assert property (@(posedge clk) disable iff (rst)
    (ds_pop && !ds_push && !ds_empty) |=> (ds_idx == $past(ds_idx) + 1'b1));

  a_r4_index_in_range: assert property (@(posedge clk) disable iff (rst)
    ds_idx <= DIW'(DS_DEPTH));

  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_OPND && ir_q == OP_JMP) |=> (mem_addr == $past(mem_rdata)));

  a_r10_return_index_range: assert property (@(posedge clk) disable iff (rst)
    (rs_idx <= RIW'(RS_DEPTH)) && !(rs_full && rs_empty));
endmodule

bind sp_core sp_core_chk #(.DS_DEPTH(DS_DEPTH), .RS_DEPTH(RS_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .mem_we(mem_we), .state_q(state_q), .ir_q(ir_q), .ds_push(ds_push),
  .ds_pop(ds_pop), .ds_full(ds_full), .ds_empty(ds_empty), .ds_idx(ds_idx),
  .rs_full(rs_full), .rs_empty(rs_empty), .rs_idx(rs_idx)
);

// File: tb/tb_sp_core.sv
`timescale 1ns/1ps
module tb_sp_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] ram [256];
  int n_checks = 0;
  int n_errs   = 0;
  int we_b2b   = 0;
  int at       = 0;
  logic we_prev = 1'b0;

  always #2.5 clk = ~clk;

  sp_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we)
  );

  // one-cycle-latency synchronous memory model
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst && mem_we && we_prev) we_b2b++;
    we_prev <= mem_we && !rst;
  end

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    at = 0;
  endtask

  task automatic emit(logic [7:0] b);
    ram[at] = b;
    at++;
  endtask

  task automatic emit2(logic [7:0] op, logic [7:0] arg);
    emit(op);
    emit(arg);
  endtask

  task automatic halt_here();
    emit2(8'h05, 8'(at));
  endtask

  task automatic start();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    prep();
    halt_here();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check8("R1 addr during reset", mem_addr, 8'h00);
    check8("R1 we during reset", {7'd0, mem_we}, 8'h00);
    start();
    check8("R1 first fetch addr", mem_addr, 8'h00);
  endtask

  task automatic t_sum();
    prep();
    ram[8'h70] = 8'h80; ram[8'h71] = 8'd5; ram[8'h72] = 8'h70; ram[8'h73] = 8'h71;
    ram[8'h80] = 8'd10; ram[8'h81] = 8'd20; ram[8'h82] = 8'd30;
    ram[8'h83] = 8'd40; ram[8'h84] = 8'd250;
    emit2(8'h01, 8'h00);            // 0: lit 0
    emit2(8'h0B, 8'h70);            // 2: pushi element
    emit(8'h02);                    // 4: pop
    emit(8'h08);                    // 5: add
    emit2(8'h0F, 8'h72);            // 6: incp pointer
    emit2(8'h0B, 8'h73);            // 8: pushi count
    emit2(8'h01, 8'h01);            // 10: lit 1
    emit(8'h02);                    // 12: pop
    emit(8'h09);                    // 13: sub
    emit2(8'h10, 8'h73);            // 14: sti count
    emit(8'h02);                    // 16: pop
    emit2(8'h06, 8'h02);            // 17: bnz loop
    emit2(8'h03, 8'hA0);            // 19: sta sum
    emit(8'h0E);                    // 21: t2n
    emit2(8'h03, 8'hA1);            // 22: sta top
    halt_here();
    start();
    repeat (400) @(negedge clk);
    check8("R5 R8 R9 sum result", ram[8'hA0], 8'h5E);
    check8("R9 loop exit TOP", ram[8'hA1], 8'h00);
    check8("R8 incp pointer", ram[8'h70], 8'h85);
    check8("R8 sti count", ram[8'h71], 8'h00);
  endtask

  task automatic t_stack();
    prep();
    emit2(8'h01, 8'h44); emit(8'h02);   // TOP=44, empty
    emit(8'h02);                        // pop on empty
    emit2(8'h01, 8'h33); emit(8'h0D);   // lit 33, swap
    emit2(8'h03, 8'hB0);
    emit(8'h0D);
    emit2(8'h03, 8'hB1);
    emit(8'h02);
    for (int v = 1; v <= 9; v++) emit2(8'h01, 8'(v));
    emit2(8'h03, 8'hB2);
    for (int k = 0; k < 7; k++) emit(8'h02);
    emit2(8'h03, 8'hB3);
    emit(8'h02); emit(8'h02);
    emit2(8'h01, 8'h5A);
    emit2(8'h03, 8'hB4);
    halt_here();
    start();
    repeat (200) @(negedge clk);
    check8("R4 empty pop zeroes TOP", ram[8'hB0], 8'h00);
    check8("R4 R6 one entry after push", ram[8'hB1], 8'h33);
    check8("R4 push on full dropped", ram[8'hB2], 8'h08);
    check8("R4 pops walk down", ram[8'hB3], 8'h01);
    check8("R4 index sane after underflow", ram[8'hB4], 8'h5A);
  endtask

  task automatic t_alu();
    prep();
    emit2(8'h01, 8'hC8); emit(8'h02);
    emit2(8'h01, 8'h64); emit(8'h08);
    emit2(8'h03, 8'hC0);
    emit(8'h09);
    emit2(8'h03, 8'hC1);
    emit2(8'h0A, 8'h77);
    emit2(8'h03, 8'hC2);
    emit(8'h0C);
    emit2(8'h0A, 8'h01);
    emit(8'h0D);
    emit2(8'h03, 8'hC3);
    emit(8'h0E);
    emit2(8'h03, 8'hC4);
    emit(8'hFF);                        // unknown opcode
    emit2(8'h0A, 8'h99);
    emit2(8'h04, 8'hC0);
    emit2(8'h03, 8'hC5);
    emit(8'h0E);
    emit2(8'h03, 8'hC6);
    halt_here();
    start();
    repeat (200) @(negedge clk);
    check8("R5 add wraps", ram[8'hC0], 8'h2C);
    check8("R5 sub wraps", ram[8'hC1], 8'h64);
    check8("R6 setn", ram[8'hC2], 8'h77);
    check8("R6 n2t then swap", ram[8'hC3], 8'h77);
    check8("R6 t2n", ram[8'hC4], 8'h01);
    check8("R2 R7 ldrot after unknown op", ram[8'hC5], 8'h2C);
    check8("R7 ldrot moves N to TOP", ram[8'hC6], 8'h99);
  endtask

  task automatic t_branch();
    prep();
    ram[8'hD0] = 8'h5A;
    emit2(8'h07, 8'h06);   // 0: bz 6 (taken)
    emit2(8'h01, 8'hEE);   // 2
    emit2(8'h03, 8'hD0);   // 4
    emit2(8'h06, 8'h0A);   // 6: bnz 10 (not taken)
    emit2(8'h01, 8'h11);   // 8
    emit2(8'h03, 8'hD1);   // 10
    emit2(8'h11, 8'h20);   // 12: call
    emit2(8'h03, 8'hD3);   // 14
    emit2(8'h01, 8'h03);   // 16
    emit(8'h02);           // 18
    emit2(8'h07, 8'h40);   // 19: bz (not taken)
    emit2(8'h03, 8'hD4);   // 21
    halt_here();           // 23
    at = 8'h20;
    emit2(8'h11, 8'h30);   // nested call
    emit2(8'h0A, 8'h55);
    emit(8'h12);
    at = 8'h30;
    emit2(8'h01, 8'h66);
    emit2(8'h03, 8'hD2);
    emit(8'h12);
    at = 8'h40;
    emit2(8'h01, 8'hBB);
    emit2(8'h03, 8'hD4);
    halt_here();
    start();
    repeat (200) @(negedge clk);
    check8("R9 bz taken skips", ram[8'hD0], 8'h5A);
    check8("R9 bnz not taken", ram[8'hD1], 8'h11);
    check8("R10 nested call body", ram[8'hD2], 8'h66);
    check8("R10 return path", ram[8'hD3], 8'h55);
    check8("R9 bz not taken", ram[8'hD4], 8'h55);
  endtask

  task automatic t_timing(logic [7:0] op, int exp_cycle, logic [7:0] exp_val, string req);
    int c;
    prep();
    ram[8'h90] = 8'h91;
    ram[8'h91] = (op == 8'h0F) ? 8'hFF : 8'h42;
    ram[8'h95] = 8'h99;
    emit2(op, (op == 8'h03) ? 8'h95 : 8'h90);
    halt_here();
    start();
    c = -1;
    for (int k = 0; k < 20; k++) begin
      if (mem_we) begin
        c = k;
        break;
      end
      @(negedge clk);
    end
    check_int(req, c, exp_cycle);
    repeat (10) @(negedge clk);
    check8({req, " data"}, ram[(op == 8'h03) ? 8'h95 : 8'h91], exp_val);
  endtask

  initial begin
    #900000;
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sum();
    t_stack();
    t_alu();
    t_branch();
    t_timing(8'h03, 2, 8'h00, "R11 R7 sta cycles");
    t_timing(8'h10, 3, 8'h00, "R11 R8 sti cycles");
    t_timing(8'h0F, 4, 8'h00, "R11 R8 incp cycles wrap");
    check_int("R3 back-to-back writes", we_b2b, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule